// File: doc/BRIEF.md
# Hard Reset Source Controller

This block merges every source of a node-wide hard reset into one internal reset state and turns that state into the reset, protect and hold signals for the rest of the node. Four requests can start a hard reset: an external active-low reset pin, a software node-reset bit, a software hard-reset bit and a bus-initialization error strobe. The external pin is synchronized to the core clock. It only counts as a request once it has stayed low for a programmable number of consecutive cycles. At 50 MHz, a count of 4 gives the 80 ns minimum width. No hard reset can begin while power-good is still low.

The block drives three reset domains: ordinary logic, preserved configuration and preserved memory-maintenance logic. Two save bits are sampled when a hard reset begins. A save bit keeps its preserved domain out of reset and raises an input fence for that domain, so idle buses and stray signals cannot change it. The processor-bus reset output follows the hard reset. A clock-restart request pulses only on the first hard reset after power-on.

Release happens in two steps. The hard reset stays active while any request is still present. After the last request goes away, it waits for the count of pending preserved-interface operations to reach zero. It then lets go of every domain, every fence and the bus reset on one clock edge.

Top module: `hard_reset_ctrl`

## Requirements
- R1: The external reset pin `ext_rst_n` starts a hard reset only after it has been sampled low for at least `min_pulse` consecutive cycles. A `min_pulse` of 0 acts as 1. A shorter low pulse has no effect on any output.
- R2: A high level on `sw_node_rst`, `sw_hard_rst` or `bus_init_err`, seen at one rising edge while power-good is high, starts a hard reset. After that edge, `rst_main_n` is 0 and `cpu_bus_rst` is 1.
- R3: While `pwr_good` is 0, no request starts a hard reset.
- R4: `clk_restart_req` is high for exactly one cycle, starting at the edge that begins the first hard reset after `por_n` releases. Later hard resets never raise it.
- R5: During a hard reset, a domain whose save bit was 1 keeps its reset output high and has its fence high. A domain whose save bit was 0 has its reset output low and its fence low. `save_cfg` controls `rst_cfg_n` and `cfg_fence`; `save_mem` controls `rst_mem_n` and `mem_fence`.
- R6: The save bits are sampled at the edge that begins a hard reset. A change to them during the hard reset has no effect until the next one.
- R7: The hard reset stays active for as long as any qualified request is present, including an external pin held low.
- R8: After all requests are gone, the hard reset stays active while `pend_cnt` is non-zero.
- R9: On release, `rst_main_n`, `rst_cfg_n` and `rst_mem_n` go high on the same edge. On that same edge both fences and `cpu_bus_rst` go to 0.
- R10: While `por_n` is low and just after it releases, every reset output is high and the fences, `cpu_bus_rst` and `clk_restart_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset of this block, active low, asynchronous |
| pwr_good | input | 1 | Power-good; requests are ignored while low |
| ext_rst_n | input | 1 | External hard reset request pin, active low, asynchronous |
| min_pulse | input | PW_W | Minimum accepted low width of `ext_rst_n`, in cycles |
| sw_node_rst | input | 1 | Software node-reset request bit |
| sw_hard_rst | input | 1 | Software hard-reset request bit |
| bus_init_err | input | 1 | Bus-initialization error strobe |
| save_cfg | input | 1 | Keep configuration domain through hard reset |
| save_mem | input | 1 | Keep memory-maintenance domain through hard reset |
| pend_cnt | input | CNT_W | Operations still open on preserved-logic interfaces |
| rst_main_n | output | 1 | Reset of ordinary logic, active low |
| rst_cfg_n | output | 1 | Reset of preserved configuration, active low |
| rst_mem_n | output | 1 | Reset of memory-maintenance logic, active low |
| cfg_fence | output | 1 | Gate inputs of configuration domain |
| mem_fence | output | 1 | Gate inputs of memory-maintenance domain |
| cpu_bus_rst | output | 1 | Processor-bus reset, high during hard reset |
| clk_restart_req | output | 1 | One-cycle clock and reference restart request |

## Verification
The hardest state to reach is a hard reset whose requests have all cleared while operations are still pending. The stimulus enters it with a single-cycle software request and a non-zero `pend_cnt`, and holds it for many cycles before clearing the count. The release edge is then located cycle by cycle, and all domains, fences and the bus reset are checked at that edge. The bench also walks the external pin right across the accepted width: one cycle short of `min_pulse`, and exactly `min_pulse`.

// File: rtl/hrst_pkg.sv
package hrst_pkg;
   typedef enum logic [1:0] {
      HR_IDLE  = 2'd0,
      HR_HOLD  = 2'd1,
      HR_DRAIN = 2'd2
   } hr_state_e;

   localparam int unsigned N_KEEP = 2;   // preserved domains: 0 = config, 1 = memory
endpackage

// File: rtl/hrst_ext_filter.sv
module hrst_ext_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PW_W        = 8
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            ext_rst_n,
   input  logic [PW_W-1:0] min_pulse,
   output logic            ext_ok
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hrst_ext_filter: SYNC_STAGES must be at least 2");
      end
      if (PW_W < 1) begin : g_bad_pw
         $error("hrst_ext_filter: PW_W must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_low;
   logic [PW_W-1:0]        run_q;
   logic [PW_W:0]          thr;
   logic [PW_W:0]          run_nx;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_rst_n};
   end

   assign sync_low = ~sync_q[SYNC_STAGES-1];
   assign thr      = (min_pulse == '0) ? (PW_W+1)'(1) : {1'b0, min_pulse};
   assign run_nx   = {1'b0, run_q} + (PW_W+1)'(1);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         run_q  <= '0;
         ext_ok <= 1'b0;
      end else if (!sync_low) begin
         run_q  <= '0;
         ext_ok <= 1'b0;
      end else if (!ext_ok) begin
         if (run_nx >= thr) ext_ok <= 1'b1;
         else               run_q  <= run_nx[PW_W-1:0];
      end
   end

   // R1: qualification only ever follows a synchronized low level
   assert_ok_after_low_R1: assert property (@(posedge clk) disable iff (!por_n)
      $rose(ext_ok) |-> $past(sync_low));
endmodule

// File: rtl/hrst_seq.sv
module hrst_seq
   import hrst_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             pwr_good,
   input  logic             req_any,
   input  logic [CNT_W-1:0] pend_cnt,
   output hr_state_e        state,
   output logic             restart_pulse
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("hrst_seq: CNT_W must be at least 1");
      end
   endgenerate

   hr_state_e state_nx;
   logic      req_ok;
   logic      first_done_q;
   logic [1:0] n_restart_q;

   assign req_ok = pwr_good & req_any;

   always_comb begin
      state_nx = state;
      unique case (state)
         HR_IDLE:  if (req_ok) state_nx = HR_HOLD;
         HR_HOLD:  if (!req_ok) state_nx = HR_DRAIN;
         HR_DRAIN: begin
            if (req_ok)                state_nx = HR_HOLD;
            else if (pend_cnt == '0)   state_nx = HR_IDLE;
         end
         default:  state_nx = HR_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state         <= HR_IDLE;
         first_done_q  <= 1'b0;
         restart_pulse <= 1'b0;
      end else begin
         state         <= state_nx;
         restart_pulse <= (state == HR_IDLE) && req_ok && !first_done_q;
         if ((state == HR_IDLE) && req_ok) first_done_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                              n_restart_q <= '0;
      else if (restart_pulse && n_restart_q != 2'd3) n_restart_q <= n_restart_q + 2'd1;
   end

   always_comb begin
      assert_restart_once_R4: assert (n_restart_q < 2'd2);
   end

   assert_no_start_unpowered_R3: assert property (@(posedge clk) disable iff (!por_n)
      (state == HR_IDLE && !pwr_good) |=> state == HR_IDLE);

   assert_pending_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
      (state != HR_IDLE && pend_cnt != '0) |=> state != HR_IDLE);

   assert_request_holds_R7: assert property (@(posedge clk) disable iff (!por_n)
      (state != HR_IDLE && req_ok) |=> state == HR_HOLD);
endmodule

// File: rtl/hrst_domain_map.sv
module hrst_domain_map
   import hrst_pkg::*;
(
   input  logic              clk,
   input  logic              por_n,
   input  logic              in_reset,
   input  logic [N_KEEP-1:0] save_vec,
   output logic [N_KEEP-1:0] keep_rst_n,
   output logic [N_KEEP-1:0] keep_fence
);
   logic [N_KEEP-1:0] keep_q;

   for (genvar d = 0; d < N_KEEP; d++) begin : g_dom
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)         keep_q[d] <= 1'b0;
         else if (!in_reset) keep_q[d] <= save_vec[d];
      end
      assign keep_rst_n[d] = ~(in_reset & ~keep_q[d]);
      assign keep_fence[d] = in_reset & keep_q[d];
   end

   // R6: the save choice is frozen for the whole hard reset
   assert_frozen_choice_R6: assert property (@(posedge clk) disable iff (!por_n)
      (in_reset && $past(in_reset)) |-> $stable(keep_rst_n) && $stable(keep_fence));
endmodule

// File: rtl/hard_reset_ctrl.sv
module hard_reset_ctrl
   import hrst_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PW_W        = 8,
   parameter int unsigned CNT_W       = 4
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             pwr_good,
   input  logic             ext_rst_n,
   input  logic [PW_W-1:0]  min_pulse,
   input  logic             sw_node_rst,
   input  logic             sw_hard_rst,
   input  logic             bus_init_err,
   input  logic             save_cfg,
   input  logic             save_mem,
   input  logic [CNT_W-1:0] pend_cnt,
   output logic             rst_main_n,
   output logic             rst_cfg_n,
   output logic             rst_mem_n,
   output logic             cfg_fence,
   output logic             mem_fence,
   output logic             cpu_bus_rst,
   output logic             clk_restart_req
);
   logic              ext_ok;
   logic              req_any;
   hr_state_e         state;
   logic              in_reset;
   logic [N_KEEP-1:0] keep_rst_n;
   logic [N_KEEP-1:0] keep_fence;

   hrst_ext_filter #(.SYNC_STAGES(SYNC_STAGES), .PW_W(PW_W)) u_filt (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
      .min_pulse(min_pulse), .ext_ok(ext_ok));

   assign req_any = ext_ok | sw_node_rst | sw_hard_rst | bus_init_err;

   hrst_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .por_n(por_n), .pwr_good(pwr_good), .req_any(req_any),
      .pend_cnt(pend_cnt), .state(state), .restart_pulse(clk_restart_req));

   assign in_reset = (state != HR_IDLE);

   hrst_domain_map u_map (
      .clk(clk), .por_n(por_n), .in_reset(in_reset),
      .save_vec({save_mem, save_cfg}),
      .keep_rst_n(keep_rst_n), .keep_fence(keep_fence));

   assign rst_main_n  = ~in_reset;
   assign cpu_bus_rst = in_reset;
   assign rst_cfg_n   = keep_rst_n[0];
   assign cfg_fence   = keep_fence[0];
   assign rst_mem_n   = keep_rst_n[1];
   assign mem_fence   = keep_fence[1];

   assert_release_together_R9: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_main_n) |-> rst_cfg_n && rst_mem_n && !cfg_fence && !mem_fence && !cpu_bus_rst);

   assert_fence_exclusive_R5: assert property (@(posedge clk) disable iff (!por_n)
      !(cfg_fence && !rst_cfg_n) && !(mem_fence && !rst_mem_n));
endmodule

// File: tb/hard_reset_ctrl_tb.sv
module hard_reset_ctrl_tb;
   localparam int PW_W  = 8;
   localparam int CNT_W = 4;

   logic clk = 1'b0;
   logic por_n, pwr_good, ext_rst_n, sw_node_rst, sw_hard_rst, bus_init_err;
   logic save_cfg, save_mem;
   logic [PW_W-1:0]  min_pulse;
   logic [CNT_W-1:0] pend_cnt;
   logic rst_main_n, rst_cfg_n, rst_mem_n, cfg_fence, mem_fence, cpu_bus_rst, clk_restart_req;

   int total = 0;
   int bad   = 0;
   int low_seen = 0;
   int restarts = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   hard_reset_ctrl #(.PW_W(PW_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .por_n(por_n), .pwr_good(pwr_good), .ext_rst_n(ext_rst_n),
      .min_pulse(min_pulse), .sw_node_rst(sw_node_rst), .sw_hard_rst(sw_hard_rst),
      .bus_init_err(bus_init_err), .save_cfg(save_cfg), .save_mem(save_mem),
      .pend_cnt(pend_cnt), .rst_main_n(rst_main_n), .rst_cfg_n(rst_cfg_n),
      .rst_mem_n(rst_mem_n), .cfg_fence(cfg_fence), .mem_fence(mem_fence),
      .cpu_bus_rst(cpu_bus_rst), .clk_restart_req(clk_restart_req));

   always @(negedge clk) begin
      if (!rst_main_n) low_seen++;
      if (clk_restart_req) restarts++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // packed outputs: {main, cfg, mem, cfence, mfence, busrst}
   function automatic logic [5:0] outs();
      return {rst_main_n, rst_cfg_n, rst_mem_n, cfg_fence, mem_fence, cpu_bus_rst};
   endfunction

   // [10]node [9]hard [8]bus [7]save_cfg [6]save_mem | [5:0] expected outs during reset
   localparam logic [10:0] VEC [5] = '{
      11'b100_00_000001,
      11'b010_10_010101,
      11'b001_01_001011,
      11'b110_11_011111,
      11'b011_00_000001
   };

   initial begin
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      chk(1'b0, "watchdog", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      por_n = 0; pwr_good = 0; ext_rst_n = 1; min_pulse = 8'd4;
      sw_node_rst = 0; sw_hard_rst = 0; bus_init_err = 0;
      save_cfg = 0; save_mem = 0; pend_cnt = '0;
      repeat (3) @(negedge clk);
      chk(outs() == 6'b111000 && !clk_restart_req, "R10 in por", int'(outs()), 6'b111000);
      por_n = 1;
      @(negedge clk);
      chk(outs() == 6'b111000 && !clk_restart_req, "R10 after por", int'(outs()), 6'b111000);

      // R3: no hard reset while power-good is low
      low_seen = 0;
      sw_hard_rst = 1; bus_init_err = 1;
      repeat (4) @(negedge clk);
      sw_hard_rst = 0; bus_init_err = 0;
      repeat (2) @(negedge clk);
      chk(low_seen == 0, "R3 unpowered request", low_seen, 0);
      pwr_good = 1;
      @(negedge clk);

      // R2 R5 R4 vector table
      for (int i = 0; i < 5; i++) begin
         sw_node_rst = VEC[i][10]; sw_hard_rst = VEC[i][9]; bus_init_err = VEC[i][8];
         save_cfg = VEC[i][7]; save_mem = VEC[i][6];
         @(negedge clk);
         sw_node_rst = 0; sw_hard_rst = 0; bus_init_err = 0;
         chk(outs() == VEC[i][5:0], "R2/R5 vector outputs", int'(outs()), int'(VEC[i][5:0]));
         chk(clk_restart_req == (i == 0), "R4 restart pulse", int'(clk_restart_req), int'(i == 0));
         save_cfg = 0; save_mem = 0;
         repeat (3) @(negedge clk);
         chk(outs() == 6'b111000, "R9 release idle", int'(outs()), 6'b111000);
      end

      // R1: pulse one cycle short of min_pulse is ignored
      low_seen = 0;
      ext_rst_n = 0;
      repeat (3) @(negedge clk);
      ext_rst_n = 1;
      repeat (10) @(negedge clk);
      chk(low_seen == 0, "R1 short pulse ignored", low_seen, 0);

      // R1: pulse of exactly min_pulse is accepted
      low_seen = 0;
      ext_rst_n = 0;
      repeat (4) @(negedge clk);
      ext_rst_n = 1;
      repeat (10) @(negedge clk);
      chk(low_seen > 0, "R1 full pulse accepted", low_seen, 1);
      chk(rst_main_n == 1, "R1 released after pulse", int'(rst_main_n), 1);

      // R7: held external pin keeps the reset
      ext_rst_n = 0;
      repeat (25) @(negedge clk);
      chk(rst_main_n == 0 && cpu_bus_rst == 1, "R7 held pin", int'(rst_main_n), 0);
      ext_rst_n = 1;
      repeat (8) @(negedge clk);
      chk(rst_main_n == 1, "R7 release after pin", int'(rst_main_n), 1);

      // R6: save choice frozen during reset
      save_cfg = 1; sw_hard_rst = 1;
      @(negedge clk);
      chk(rst_cfg_n == 1 && cfg_fence == 1, "R6 keep at entry", int'(rst_cfg_n), 1);
      save_cfg = 0; save_mem = 1;
      repeat (3) @(negedge clk);
      chk(rst_cfg_n == 1 && cfg_fence == 1, "R6 cfg frozen", int'(cfg_fence), 1);
      chk(rst_mem_n == 0 && mem_fence == 0, "R6 mem frozen", int'(rst_mem_n), 0);
      sw_hard_rst = 0; save_mem = 0;
      repeat (3) @(negedge clk);

      // R8 R9: pending operations hold release, then all let go together
      pend_cnt = 4'd3;
      sw_node_rst = 1;
      @(negedge clk);
      sw_node_rst = 0;
      repeat (12) @(negedge clk);
      chk(rst_main_n == 0 && rst_cfg_n == 0 && rst_mem_n == 0, "R8 pending hold",
          int'(rst_main_n), 0);
      pend_cnt = '0;
      for (int k = 0; k < 5 && rst_main_n == 0; k++) @(negedge clk);
      chk(outs() == 6'b111000, "R9 same-edge release", int'(outs()), 6'b111000);

      chk(restarts == 1, "R4 single restart overall", restarts, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule